// File: doc/BRIEF.md
# Banked CPU Bus Address Generator

This block produces the 24-bit address and the access kind for every bus cycle of a 16-bit processor whose address space is split into 256 banks of 64 KiB. A sequencer sends a 4-bit micro-op code with a valid strobe. Each code names one cycle kind: an instruction fetch from the program counter, a data read or write, a stack push or pull, or a dummy stack touch. The block turns that code into a registered bus address and a registered access kind. It also moves the registers that the cycle uses.

The block owns the program counter, the program bank, the 24-bit data address, the stack pointer and the emulation flag. Some micro-ops drive no bus cycle. These build a data address from an operand, in absolute or indexed-indirect form, or perform a long jump or a subroutine jump. A separate load port lets the controller overwrite the data address, the stack pointer and the emulation flag. Opcode decode, arithmetic and interrupt sequencing live outside this block.

Top module: `bus_addr_gen`

## Requirements
- R1: After reset, pc=0x0000, pbank=0x00, data_addr=0x000000, sp=0x01FF, emu=1, ret_pc=0x0000, bus_addr=0x000000 and bus_type=0 (idle). The bus_type encoding is 0 idle, 1 read, 2 write, 3 opcode fetch.
- R2: Codes 1 (opcode fetch, bus_type 3), 2 (operand fetch, bus_type 1) and 3 (plain PC read, bus_type 1) put {pbank, pc} on bus_addr. Codes 1 and 2 then advance pc by one, modulo 65536, and leave pbank unchanged. Code 3 leaves pc unchanged.
- R3: Codes 4 (read), 5 (read then increment), 6 (write), 7 (write then increment) and 8 (write then decrement) put data_addr on bus_addr, with bus_type 1 for the reads and 2 for the writes. Each step changes only data_addr[15:0], modulo 65536, and keeps data_addr[23:16].
- R4: When emu=1, a stack address is {8'h00, 8'h01, sp[7:0]}. When emu=0, it is {8'h00, sp}.
- R5: Code 9 (push) writes (bus_type 2) at the current stack address, then sp decreases by one. Code 10 (pull) increases sp by one and reads (bus_type 1) at the stack address of the new sp. Code 11 reads at the current stack address and leaves sp unchanged. All sp arithmetic is 16-bit.
- R6: Code 12 sets data_addr to {dbank, operand[15:0]}.
- R7: Code 13 sets data_addr to {8'h00, (operand[15:0] + X) mod 65536}. X is x_reg, or x_reg[7:0] zero-extended when idx8=1.
- R8: Code 14 sets pbank to operand[23:16] and pc to operand[15:0].
- R9: Code 15 sets pc to operand[15:0] and ret_pc to the pc value before the jump. pbank does not change.
- R10: When load_en=1, data_addr, sp and emu take load_addr, load_sp and load_emu at the edge, whether or not uop_valid is high. This overrides any step or build that the micro-op requests for those registers in the same cycle.
- R11: When uop_valid=0, and for codes 0 and 12 to 15, bus_type becomes 0 and bus_addr holds its value. With uop_valid=0, no register other than the load port's targets changes.
- R12: All outputs are registered. A micro-op presented before a rising edge is visible on the outputs only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | Micro-op strobe |
| uop | input | 4 | Micro-op code |
| operand | input | 24 | Operand from the instruction bytes |
| x_reg | input | 16 | X index register value |
| idx8 | input | 1 | Index registers are 8 bits wide |
| dbank | input | 8 | Data bank register value |
| load_en | input | 1 | Direct load strobe |
| load_addr | input | 24 | Data address to load |
| load_sp | input | 16 | Stack pointer to load |
| load_emu | input | 1 | Emulation flag to load |
| bus_addr | output | 24 | Registered bus address |
| bus_type | output | 2 | Registered access kind |
| pc | output | 16 | Program counter |
| pbank | output | 8 | Program bank |
| data_addr | output | 24 | Data address |
| sp | output | 16 | Stack pointer |
| emu | output | 1 | Emulation flag |
| ret_pc | output | 16 | PC saved by the subroutine jump |

## Verification
Directed cases cover the wrap points. A data address at xxFFFF is stepped up and at xx0000 stepped down, which separates offset wrap from carry into the bank. The PC is fetched from 0xFFFF, which shows whether the bank stays put. An indexed sum overflows with idx8 set and cleared, which shows whether the X mask is applied. Push and pull run in both stack modes, and one pull coincides with a load, which separates pre-increment from post-increment and shows that the load has priority. A long seeded random run then mixes every code with dropped strobes and stray loads, and every register output is compared with a bench model each cycle.

// File: rtl/bagen_pkg.sv
package bagen_pkg;
  localparam int OFS_W  = 16;
  localparam int BNK_W  = 8;
  localparam int ADDR_W = OFS_W + BNK_W;
  localparam int PAGE_W = OFS_W - 8;

  typedef enum logic [3:0] {
    UOP_NOP       = 4'd0,
    UOP_FETCH_OPC = 4'd1,
    UOP_FETCH_ARG = 4'd2,
    UOP_PEEK_PC   = 4'd3,
    UOP_RD        = 4'd4,
    UOP_RD_INC    = 4'd5,
    UOP_WR        = 4'd6,
    UOP_WR_INC    = 4'd7,
    UOP_WR_DEC    = 4'd8,
    UOP_PUSH      = 4'd9,
    UOP_PULL      = 4'd10,
    UOP_STK_TOUCH = 4'd11,
    UOP_MK_ABS    = 4'd12,
    UOP_MK_IDXIND = 4'd13,
    UOP_JMP_LONG  = 4'd14,
    UOP_JMP_SUB   = 4'd15
  } uop_e;

  typedef enum logic [1:0] {
    BUS_IDLE    = 2'd0,
    BUS_READ    = 2'd1,
    BUS_WRITE   = 2'd2,
    BUS_OPFETCH = 2'd3
  } bus_e;

  // Step the offset part of an address; the bank byte is carried unchanged.
  function automatic logic [ADDR_W-1:0] step_in_bank(input logic [ADDR_W-1:0] a,
                                                     input logic down);
    logic [OFS_W-1:0] ofs;
    ofs = down ? (a[OFS_W-1:0] - 1'b1) : (a[OFS_W-1:0] + 1'b1);
    return {a[ADDR_W-1:OFS_W], ofs};
  endfunction

  // Stack address: fixed page in emulation mode, full pointer otherwise.
  function automatic logic [ADDR_W-1:0] stack_addr(input logic [OFS_W-1:0] s,
                                                   input logic e,
                                                   input logic [PAGE_W-1:0] page);
    if (e) return {{BNK_W{1'b0}}, page, s[7:0]};
    return {{BNK_W{1'b0}}, s};
  endfunction

  function automatic logic [ADDR_W-1:0] idx_ind_addr(input logic [OFS_W-1:0] base,
                                                     input logic [OFS_W-1:0] x,
                                                     input logic narrow);
    logic [OFS_W-1:0] xm;
    xm = narrow ? {{PAGE_W{1'b0}}, x[7:0]} : x;
    return {{BNK_W{1'b0}}, base + xm};
  endfunction

  function automatic bus_e bus_kind(input uop_e op);
    case (op)
      UOP_FETCH_OPC:                                  return BUS_OPFETCH;
      UOP_FETCH_ARG, UOP_PEEK_PC, UOP_RD, UOP_RD_INC,
      UOP_PULL, UOP_STK_TOUCH:                        return BUS_READ;
      UOP_WR, UOP_WR_INC, UOP_WR_DEC, UOP_PUSH:       return BUS_WRITE;
      default:                                        return BUS_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/bagen_pc_unit.sv
module bagen_pc_unit
  import bagen_pkg::*;
#(
  parameter int PW = OFS_W,
  parameter int BW = BNK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  uop_e          op,
  input  logic [PW+BW-1:0] operand,
  output logic [PW-1:0] pc,
  output logic [BW-1:0] pbank,
  output logic [PW-1:0] ret_pc,
  output logic          pc_advance
);
  assign pc_advance = fire && (op == UOP_FETCH_OPC || op == UOP_FETCH_ARG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      pbank  <= '0;
      ret_pc <= '0;
    end else if (fire) begin
      case (op)
        UOP_FETCH_OPC, UOP_FETCH_ARG: pc <= pc + 1'b1;
        UOP_JMP_LONG: begin
          pbank <= operand[PW+BW-1:PW];
          pc    <= operand[PW-1:0];
        end
        UOP_JMP_SUB: begin
          ret_pc <= pc;
          pc     <= operand[PW-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bagen_data_unit.sv
module bagen_data_unit
  import bagen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  uop_e              op,
  input  logic [ADDR_W-1:0] operand,
  input  logic [OFS_W-1:0]  x_reg,
  input  logic              idx8,
  input  logic [BNK_W-1:0]  dbank,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] data_addr,
  output logic              data_step
);
  logic [ADDR_W-1:0] nxt;

  assign data_step = fire && (op == UOP_RD_INC || op == UOP_WR_INC || op == UOP_WR_DEC);

  always_comb begin
    nxt = data_addr;
    if (fire) begin
      case (op)
        UOP_RD_INC, UOP_WR_INC: nxt = step_in_bank(data_addr, 1'b0);
        UOP_WR_DEC:             nxt = step_in_bank(data_addr, 1'b1);
        UOP_MK_ABS:             nxt = {dbank, operand[OFS_W-1:0]};
        UOP_MK_IDXIND:          nxt = idx_ind_addr(operand[OFS_W-1:0], x_reg, idx8);
        default: ;
      endcase
    end
    if (load_en) nxt = load_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_addr <= '0;
    else        data_addr <= nxt;
  end
endmodule

// File: rtl/bagen_stack_unit.sv
module bagen_stack_unit
  import bagen_pkg::*;
#(
  parameter logic [OFS_W-1:0]  SP_RESET = 16'h01FF,
  parameter logic [PAGE_W-1:0] EMU_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  uop_e              op,
  input  logic              load_en,
  input  logic [OFS_W-1:0]  load_sp,
  input  logic              load_emu,
  output logic [OFS_W-1:0]  sp,
  output logic              emu,
  output logic [ADDR_W-1:0] access_addr,
  output logic              sp_push,
  output logic              sp_pull
);
  logic [OFS_W-1:0] sp_up;

  assign sp_push = fire && (op == UOP_PUSH);
  assign sp_pull = fire && (op == UOP_PULL);
  assign sp_up   = sp + 1'b1;
  // Pull pre-increments, so its access uses the already advanced pointer.
  assign access_addr = stack_addr(sp_pull ? sp_up : sp, emu, EMU_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= SP_RESET;
      emu <= 1'b1;
    end else if (load_en) begin
      sp  <= load_sp;
      emu <= load_emu;
    end else if (sp_push) begin
      sp <= sp - 1'b1;
    end else if (sp_pull) begin
      sp <= sp_up;
    end
  end
endmodule

// File: rtl/bus_addr_gen.sv
module bus_addr_gen
  import bagen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uop_valid,
  input  logic [3:0]        uop,
  input  logic [ADDR_W-1:0] operand,
  input  logic [OFS_W-1:0]  x_reg,
  input  logic              idx8,
  input  logic [BNK_W-1:0]  dbank,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [OFS_W-1:0]  load_sp,
  input  logic              load_emu,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_type,
  output logic [OFS_W-1:0]  pc,
  output logic [BNK_W-1:0]  pbank,
  output logic [ADDR_W-1:0] data_addr,
  output logic [OFS_W-1:0]  sp,
  output logic              emu,
  output logic [OFS_W-1:0]  ret_pc
);
  uop_e              op;
  bus_e              kind;
  logic [ADDR_W-1:0] stk_addr;
  logic [ADDR_W-1:0] addr_nxt;
  logic              pc_advance, data_step, sp_push, sp_pull;

  assign op   = uop_e'(uop);
  assign kind = uop_valid ? bus_kind(op) : BUS_IDLE;

  bagen_pc_unit u_pc (
    .clk(clk), .rst_n(rst_n), .fire(uop_valid), .op(op), .operand(operand),
    .pc(pc), .pbank(pbank), .ret_pc(ret_pc), .pc_advance(pc_advance)
  );

  bagen_data_unit u_data (
    .clk(clk), .rst_n(rst_n), .fire(uop_valid), .op(op), .operand(operand),
    .x_reg(x_reg), .idx8(idx8), .dbank(dbank), .load_en(load_en),
    .load_addr(load_addr), .data_addr(data_addr), .data_step(data_step)
  );

  bagen_stack_unit u_stack (
    .clk(clk), .rst_n(rst_n), .fire(uop_valid), .op(op), .load_en(load_en),
    .load_sp(load_sp), .load_emu(load_emu), .sp(sp), .emu(emu),
    .access_addr(stk_addr), .sp_push(sp_push), .sp_pull(sp_pull)
  );

  always_comb begin
    addr_nxt = bus_addr;
    case (op)
      UOP_FETCH_OPC, UOP_FETCH_ARG, UOP_PEEK_PC: addr_nxt = {pbank, pc};
      UOP_RD, UOP_RD_INC, UOP_WR, UOP_WR_INC, UOP_WR_DEC: addr_nxt = data_addr;
      UOP_PUSH, UOP_PULL, UOP_STK_TOUCH: addr_nxt = stk_addr;
      default: ;
    endcase
    if (kind == BUS_IDLE) addr_nxt = bus_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_type <= BUS_IDLE;
    end else begin
      bus_addr <= addr_nxt;
      bus_type <= kind;
    end
  end
endmodule

// File: rtl/bagen_checker.sv
module bagen_checker
  import bagen_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              uop_valid,
  input logic [3:0]        uop,
  input logic              load_en,
  input logic [OFS_W-1:0]  load_sp,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_type,
  input logic [OFS_W-1:0]  pc,
  input logic [BNK_W-1:0]  pbank,
  input logic [ADDR_W-1:0] data_addr,
  input logic [OFS_W-1:0]  sp,
  input logic              emu,
  input logic              pc_advance,
  input logic              data_step,
  input logic              sp_push
);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_advance |=> (pc == $past(pc) + 16'd1) && (pbank == $past(pbank)));

  assert_bank_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && !load_en) |=> data_addr[23:16] == $past(data_addr[23:16]));

  assert_emu_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_push && emu) |=> bus_addr[23:8] == 16'h0001);

  assert_push_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_push && !load_en) |=> (sp == $past(sp) - 16'd1) && (bus_type == 2'd2));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> sp == $past(load_sp));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !uop_valid |=> (bus_type == 2'd0) && $stable(bus_addr) && $stable(pc));

  assert_fetch_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop == 4'd1) |=> bus_type == 2'd3);
endmodule

bind bus_addr_gen bagen_checker u_bagen_checker (
  .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop(uop), .load_en(load_en),
  .load_sp(load_sp), .bus_addr(bus_addr), .bus_type(bus_type), .pc(pc),
  .pbank(pbank), .data_addr(data_addr), .sp(sp), .emu(emu),
  .pc_advance(pc_advance), .data_step(data_step), .sp_push(sp_push)
);

// File: tb/bus_addr_gen_bench.sv
module bus_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uop_valid = 1'b0;
  logic [3:0]  uop = 4'd0;
  logic [23:0] operand = '0;
  logic [15:0] x_reg = '0;
  logic        idx8 = 1'b0;
  logic [7:0]  dbank = '0;
  logic        load_en = 1'b0;
  logic [23:0] load_addr = '0;
  logic [15:0] load_sp = '0;
  logic        load_emu = 1'b0;
  logic [23:0] bus_addr;
  logic [1:0]  bus_type;
  logic [15:0] pc;
  logic [7:0]  pbank;
  logic [23:0] data_addr;
  logic [15:0] sp;
  logic        emu;
  logic [15:0] ret_pc;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic [23:0] m_bus;
  logic [1:0]  m_type;
  logic [15:0] m_pc, m_sp, m_ret;
  logic [7:0]  m_pb;
  logic [23:0] m_da;
  logic        m_emu;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_addr_gen u_bus_addr_gen (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop(uop), .operand(operand),
    .x_reg(x_reg), .idx8(idx8), .dbank(dbank), .load_en(load_en),
    .load_addr(load_addr), .load_sp(load_sp), .load_emu(load_emu),
    .bus_addr(bus_addr), .bus_type(bus_type), .pc(pc), .pbank(pbank),
    .data_addr(data_addr), .sp(sp), .emu(emu), .ret_pc(ret_pc)
  );

  function automatic logic [23:0] b_stack(input logic [15:0] s, input logic e);
    return e ? (24'h000100 | {16'h0, s[7:0]}) : {8'h00, s};
  endfunction

  function automatic string tag_of(input logic v, input logic [3:0] c);
    if (!v) return "R11";
    if (c == 0 || c >= 12) begin
      case (c)
        4'd12: return "R6";
        4'd13: return "R7";
        4'd14: return "R8";
        4'd15: return "R9";
        default: return "R11";
      endcase
    end
    if (c <= 3) return "R2";
    if (c <= 8) return "R3";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Advance the model by one edge using the current inputs.
  task automatic model_step();
    logic [15:0] o;
    logic [23:0] nb;
    logic [1:0]  nt;
    nb = m_bus; nt = 2'd0;
    if (uop_valid) begin
      case (uop)
        4'd1, 4'd2, 4'd3: begin
          nb = {m_pb, m_pc}; nt = (uop == 4'd1) ? 2'd3 : 2'd1;
          if (uop != 4'd3) m_pc = m_pc + 16'd1;
        end
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8: begin
          nb = m_da; nt = (uop <= 4'd5) ? 2'd1 : 2'd2;
          o = m_da[15:0];
          if (uop == 4'd5 || uop == 4'd7) o = o + 16'd1;
          if (uop == 4'd8) o = o - 16'd1;
          if (!load_en) m_da = {m_da[23:16], o};
        end
        4'd9:  begin nb = b_stack(m_sp, m_emu); nt = 2'd2; if (!load_en) m_sp = m_sp - 16'd1; end
        4'd10: begin nb = b_stack(m_sp + 16'd1, m_emu); nt = 2'd1; if (!load_en) m_sp = m_sp + 16'd1; end
        4'd11: begin nb = b_stack(m_sp, m_emu); nt = 2'd1; end
        4'd12: if (!load_en) m_da = {dbank, operand[15:0]};
        4'd13: if (!load_en) m_da = {8'h00, operand[15:0] + (idx8 ? {8'h00, x_reg[7:0]} : x_reg)};
        4'd14: begin m_pb = operand[23:16]; m_pc = operand[15:0]; end
        4'd15: begin m_ret = m_pc; m_pc = operand[15:0]; end
        default: ;
      endcase
    end
    if (load_en) begin
      m_da = load_addr; m_sp = load_sp; m_emu = load_emu;
    end
    m_bus = nb; m_type = nt;
  endtask

  task automatic cycle();
    string t;
    t = tag_of(uop_valid, uop);
    if (load_en) t = {t, "/R10"};
    model_step();
    @(posedge clk);
    @(negedge clk);
    // R12: results appear after the edge; compared as one registered snapshot
    check(t, {bus_addr, bus_type, pc, pbank, data_addr, sp, emu, ret_pc},
             {m_bus, m_type, m_pc, m_pb, m_da, m_sp, m_emu, m_ret});
  endtask

  task automatic set_op(input logic v, input logic [3:0] c, input logic [23:0] opd);
    uop_valid = v; uop = c; operand = opd; load_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_bus = 0; m_type = 0; m_pc = 0; m_sp = 16'h01FF; m_ret = 0; m_pb = 0; m_da = 0; m_emu = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, written as literals
    check("R1", {bus_addr, bus_type, pc, pbank, data_addr, sp, emu, ret_pc},
                {24'h0, 2'd0, 16'h0, 8'h0, 24'h0, 16'h01FF, 1'b1, 16'h0});

    // R12: a strobe before the edge does not show before it
    set_op(1'b1, 4'd1, 24'h0);
    #1;
    check("R12", {16'h0, pc}, {16'h0, 16'h0000});
    cycle();
    check("R2", {bus_addr, bus_type, pc}, {24'h000000, 2'd3, 16'h0001});

    // R10 load with no strobe
    set_op(1'b0, 4'd0, 24'h0);
    load_en = 1'b1; load_addr = 24'h12FFFF; load_sp = 16'h01FF; load_emu = 1'b1;
    cycle();
    check("R10", data_addr, 24'h12FFFF);

    // R3 increment wraps in the offset, bank kept
    set_op(1'b1, 4'd5, 24'h0);
    cycle();
    check("R3", {bus_addr, bus_type, data_addr}, {24'h12FFFF, 2'd1, 24'h120000});
    set_op(1'b1, 4'd8, 24'h0);
    cycle();
    check("R3", {bus_addr, bus_type, data_addr}, {24'h120000, 2'd2, 24'h12FFFF});

    // R4/R5 emulation push
    set_op(1'b1, 4'd9, 24'h0);
    cycle();
    check("R4", {bus_addr, bus_type, sp}, {24'h0001FF, 2'd2, 16'h01FE});

    // R10 load beats a pull in the same cycle; pull address from old state
    set_op(1'b1, 4'd10, 24'h0);
    load_en = 1'b1; load_addr = 24'h550000; load_sp = 16'h3456; load_emu = 1'b0;
    cycle();
    check("R10", {bus_addr, sp, emu}, {24'h0001FF, 16'h3456, 1'b0});

    // R4/R5 native push and pull
    set_op(1'b1, 4'd9, 24'h0);
    cycle();
    check("R5", {bus_addr, sp}, {24'h003456, 16'h3455});
    set_op(1'b1, 4'd10, 24'h0);
    cycle();
    check("R5", {bus_addr, bus_type, sp}, {24'h003456, 2'd1, 16'h3456});
    set_op(1'b1, 4'd11, 24'h0);
    cycle();
    check("R5", {bus_addr, sp}, {24'h003456, 16'h3456});

    // R6 absolute
    set_op(1'b1, 4'd12, 24'hAA1234); dbank = 8'h7C;
    cycle();
    check("R6", {data_addr, bus_type}, {24'h7C1234, 2'd0});

    // R7 indexed indirect, narrow and wide index
    set_op(1'b1, 4'd13, 24'h00FFF0); x_reg = 16'hAB20; idx8 = 1'b1;
    cycle();
    check("R7", data_addr, 24'h000010);
    idx8 = 1'b0; x_reg = 16'h0010;
    cycle();
    check("R7", data_addr, 24'h000000);

    // R8 long jump, then fetch at the top of the bank
    set_op(1'b1, 4'd14, 24'h7EFFFF);
    cycle();
    check("R8", {pbank, pc}, {8'h7E, 16'hFFFF});
    set_op(1'b1, 4'd2, 24'h0);
    cycle();
    check("R2", {bus_addr, bus_type, pbank, pc}, {24'h7EFFFF, 2'd1, 8'h7E, 16'h0000});
    set_op(1'b1, 4'd3, 24'h0);
    cycle();
    check("R2", {bus_addr, pc}, {24'h7E0000, 16'h0000});

    // R9 subroutine jump
    set_op(1'b1, 4'd15, 24'h991234);
    cycle();
    check("R9", {pbank, pc, ret_pc}, {8'h7E, 16'h1234, 16'h0000});

    // R11 dropped strobe with a push code present
    set_op(1'b0, 4'd9, 24'h0);
    cycle();
    check("R11", {bus_addr, bus_type, sp, pc}, {24'h7E0000, 2'd0, 16'h3456, 16'h1234});

    // Seeded random run
    for (int i = 0; i < 4000; i++) begin
      uop_valid = ($urandom % 10) != 0;
      uop       = 4'($urandom);
      operand   = 24'($urandom);
      x_reg     = 16'($urandom);
      idx8      = 1'($urandom);
      dbank     = 8'($urandom);
      load_en   = ($urandom % 16) == 0;
      load_addr = 24'($urandom);
      load_sp   = 16'($urandom);
      load_emu  = 1'($urandom);
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule